// File: doc/BRIEF.md
# UART FIFO Level and Interrupt Unit

This block sits between a UART serializer and a word-wide register bus. It buffers outgoing bytes in a transmit queue and incoming bytes in a receive queue. It reports how full each queue is and turns four conditions into maskable interrupts: the receive queue reaching a programmable level, the transmit queue draining below a programmable level, a line break reported by the serializer, and a receive idle timeout measured in bit times. It also produces a ready-to-receive output for hardware flow control, and gates the transmit byte offer with a clear-to-send input.

Software works through eight word registers selected by a 3-bit address. Address 0 pushes a transmit byte. Address 1 pops a receive byte. Address 2 holds the queue levels. Address 3 is the interrupt enable. Address 4 is the write-one-to-clear register. Address 5 is the control register. Address 6 holds the thresholds. Address 7 is the masked interrupt status.

On the core side, the serializer pulls transmit bytes with a take strobe and pushes received bytes with a put strobe. It also supplies a one-cycle break pulse and a one-cycle pulse for every bit time.

Top module: `uart_fifo_irq`

## Requirements
- R1: Each queue holds DEPTH entries. The level register (address 2) gives the receive count in bits 7:0 and the transmit count in bits 15:8. A write to address 0 while the transmit queue is full is dropped, and the level stays at DEPTH.
- R2: A read of address 1 returns receive bytes in arrival order and removes one entry per read. A read while the receive queue is empty returns zero and leaves the count at zero.
- R3: The threshold register (address 6) holds the receive-full level in bits 6:0 and the transmit-empty level in bits 14:8. Both reset to DEPTH/2, and every other bit reads zero.
- R4: Pending bit 0 (receive full) is set while the receive count is at or above its level. Pending bit 1 (transmit empty) is set while the transmit count is below its level. Both follow the counts one cycle later.
- R5: A pulse on coreBreak sets pending bit 7, which then stays set until it is cleared.
- R6: Pending bit 13 (timeout) is set when the receive queue is not empty and the number of bit-time pulses since the last received byte reaches the timeout field, control bits 13:9. A field value of zero, or an empty receive queue, never sets it.
- R7: Interrupt enable (address 3) implements only bits 0, 1, 7 and 13. Masked status (address 7) is the pending bits ANDed with the enables, so it reads zero when nothing enabled is pending. irq is high exactly when masked status is non-zero. A sticky bit that is pending while disabled appears once it is enabled.
- R8: Writing ones to address 4 clears the sticky bits 7 and 13. Writing all ones clears both. A new event in the same cycle wins over the clear.
- R9: With control bit 7 set, rtsReady is low while the receive count is at or above control bits 6:0. Otherwise rtsReady is high.
- R10: coreTxAvail is high when the transmit queue is not empty, unless control bit 8 is set and ctsIn is low.
- R11: Control register (address 5) keeps bits 15:0, and the bits above read zero. Bit 14 drives loopbackEn and bit 15 drives dmaReqEn.
- R12: After reset both levels are zero, the enables and control are zero, masked status is zero, irq is low and rtsReady is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| busWrEn | input | 1 | Register write strobe |
| busRdEn | input | 1 | Register read strobe (pops at address 1) |
| busAddr | input | 3 | Register select |
| busWrData | input | 32 | Write data |
| busRdData | output | 32 | Read data for the selected register |
| coreTxTake | input | 1 | Serializer takes the head transmit byte |
| coreTxByte | output | 8 | Head of the transmit queue |
| coreTxAvail | output | 1 | Transmit byte offered to the serializer |
| coreRxPut | input | 1 | Serializer delivers a received byte |
| coreRxByte | input | 8 | Received byte |
| coreBreak | input | 1 | One-cycle break indication |
| coreBitTick | input | 1 | One pulse per bit time |
| ctsIn | input | 1 | Clear-to-send from the far end |
| rtsReady | output | 1 | Ready-to-receive flow-control output |
| irq | output | 1 | Combined interrupt |
| loopbackEn | output | 1 | Loopback request to the serializer |
| dmaReqEn | output | 1 | DMA request enable |

## Verification
The bench builds the block with DEPTH set to 16. This lets a run of seventeen writes overfill the transmit queue and reach the dropped-write case, which a 128-entry queue would make slow. With that depth the default thresholds reset to 8, so the reset readback shows the DEPTH/2 rule. Every threshold comparison, including the level at which flow control stops, lies within a few pushes.

// File: rtl/uart_irq_pkg.sv
package uart_irq_pkg;

  typedef enum logic [2:0] {
    ADDR_TXDATA = 3'd0,
    ADDR_RXDATA = 3'd1,
    ADDR_LEVELS = 3'd2,
    ADDR_IEN    = 3'd3,
    ADDR_ICLR   = 3'd4,
    ADDR_CTRL   = 3'd5,
    ADDR_THRESH = 3'd6,
    ADDR_MSTAT  = 3'd7
  } regAddr_e;

  localparam int BIT_RXFULL  = 0;
  localparam int BIT_TXEMPTY = 1;
  localparam int BIT_BREAK   = 7;
  localparam int BIT_TOUT    = 13;

  localparam logic [31:0] IRQ_MASK = 32'h0000_2083;
  localparam int LEVEL_W = 8;
  localparam int THLD_W  = 7;
  localparam int TOUT_W  = 5;

  // strobes from control to datapath
  typedef struct packed {
    logic       txPush;
    logic       rxPop;
    logic [7:0] txData;
  } dpStrobe_t;

endpackage

// File: rtl/uart_irq_fifo.sv
module uart_irq_fifo #(
  parameter int DEPTH = 128,
  parameter int WIDTH = 8,
  localparam int CW = $clog2(DEPTH + 1),
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             push,
  input  logic             pop,
  input  logic [WIDTH-1:0] wrData,
  output logic [WIDTH-1:0] rdData,
  output logic [CW-1:0]    count
);

  localparam logic [PW-1:0] LAST = PW'(DEPTH - 1);

  logic [WIDTH-1:0] mem [DEPTH];
  logic [PW-1:0] wrPtr, rdPtr;
  logic doPush, doPop;

  assign doPush = push && (count != CW'(DEPTH));
  assign doPop  = pop && (count != '0);

  always_ff @(posedge clk) begin
    if (doPush) mem[wrPtr] <= wrData;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      wrPtr <= '0;
      rdPtr <= '0;
      count <= '0;
    end else begin
      if (doPush) wrPtr <= (wrPtr == LAST) ? '0 : wrPtr + 1'b1;
      if (doPop)  rdPtr <= (rdPtr == LAST) ? '0 : rdPtr + 1'b1;
      count <= count + CW'(doPush) - CW'(doPop);
    end
  end

  assign rdData = (count == '0) ? '0 : mem[rdPtr];

endmodule

// File: rtl/uart_irq_datapath.sv
module uart_irq_datapath
  import uart_irq_pkg::*;
#(
  parameter int DEPTH = 128,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic               clk,
  input  logic               rstN,
  input  dpStrobe_t          strobe,
  input  logic               coreTxTake,
  input  logic               coreRxPut,
  input  logic [7:0]         coreRxByte,
  output logic [7:0]         txHead,
  output logic [7:0]         rxHead,
  output logic [LEVEL_W-1:0] txLevel,
  output logic [LEVEL_W-1:0] rxLevel
);

  logic [CW-1:0] txCount, rxCount;

  uart_irq_fifo #(.DEPTH(DEPTH), .WIDTH(8)) txQ_i (
    .clk(clk), .rstN(rstN),
    .push(strobe.txPush), .pop(coreTxTake),
    .wrData(strobe.txData), .rdData(txHead), .count(txCount)
  );

  uart_irq_fifo #(.DEPTH(DEPTH), .WIDTH(8)) rxQ_i (
    .clk(clk), .rstN(rstN),
    .push(coreRxPut), .pop(strobe.rxPop),
    .wrData(coreRxByte), .rdData(rxHead), .count(rxCount)
  );

  assign txLevel = LEVEL_W'(txCount);
  assign rxLevel = LEVEL_W'(rxCount);

endmodule

// File: rtl/uart_irq_control.sv
module uart_irq_control
  import uart_irq_pkg::*;
#(
  parameter int DEPTH = 128
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               busWrEn,
  input  logic               busRdEn,
  input  logic [2:0]         busAddr,
  input  logic [31:0]        busWrData,
  output logic [31:0]        busRdData,
  input  logic [7:0]         rxHead,
  input  logic [LEVEL_W-1:0] txLevel,
  input  logic [LEVEL_W-1:0] rxLevel,
  input  logic               coreRxPut,
  input  logic               coreBreak,
  input  logic               coreBitTick,
  input  logic               ctsIn,
  output dpStrobe_t          strobe,
  output logic               coreTxAvail,
  output logic               rtsReady,
  output logic               irq,
  output logic               loopbackEn,
  output logic               dmaReqEn,
  output logic               pendBrk,
  output logic               pendTout
);

  localparam logic [THLD_W-1:0] THLD_DEF = THLD_W'(DEPTH / 2);

  logic [31:0]        ienQ;
  logic [15:0]        ctrlQ;
  logic [THLD_W-1:0]  rxThld, txThld;
  logic               pendRxFull, pendTxEmpty;
  logic [TOUT_W-1:0]  idleCnt;
  logic [31:0]        pendVec, masked;

  logic wrIen, wrIclr, wrCtrl, wrThresh;
  logic [THLD_W-1:0] flowThld;
  logic rxFlowEn, txFlowEn;
  logic [TOUT_W-1:0] toutThld;
  logic toutEvent, rxEmpty;

  assign wrIen    = busWrEn && (busAddr == ADDR_IEN);
  assign wrIclr   = busWrEn && (busAddr == ADDR_ICLR);
  assign wrCtrl   = busWrEn && (busAddr == ADDR_CTRL);
  assign wrThresh = busWrEn && (busAddr == ADDR_THRESH);

  assign flowThld   = ctrlQ[6:0];
  assign rxFlowEn   = ctrlQ[7];
  assign txFlowEn   = ctrlQ[8];
  assign toutThld   = ctrlQ[13:9];
  assign loopbackEn = ctrlQ[14];
  assign dmaReqEn   = ctrlQ[15];

  assign strobe.txPush = busWrEn && (busAddr == ADDR_TXDATA);
  assign strobe.rxPop  = busRdEn && (busAddr == ADDR_RXDATA);
  assign strobe.txData = busWrData[7:0];

  assign rxEmpty   = (rxLevel == '0);
  assign toutEvent = coreBitTick && !rxEmpty && !coreRxPut &&
                     (toutThld != '0) && ((idleCnt + 1'b1) == toutThld);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      ienQ        <= '0;
      ctrlQ       <= '0;
      rxThld      <= THLD_DEF;
      txThld      <= THLD_DEF;
      pendRxFull  <= 1'b0;
      pendTxEmpty <= 1'b0;
      pendBrk     <= 1'b0;
      pendTout    <= 1'b0;
      idleCnt     <= '0;
    end else begin
      if (wrIen)  ienQ  <= busWrData & IRQ_MASK;
      if (wrCtrl) ctrlQ <= busWrData[15:0];
      if (wrThresh) begin
        rxThld <= busWrData[6:0];
        txThld <= busWrData[14:8];
      end
      pendRxFull  <= rxLevel >= {1'b0, rxThld};
      pendTxEmpty <= txLevel <  {1'b0, txThld};
      pendBrk  <= coreBreak || (pendBrk && !(wrIclr && busWrData[BIT_BREAK]));
      pendTout <= toutEvent || (pendTout && !(wrIclr && busWrData[BIT_TOUT]));
      if (coreRxPut || rxEmpty)
        idleCnt <= '0;
      else if (coreBitTick && (idleCnt != '1))
        idleCnt <= idleCnt + 1'b1;
    end
  end

  always_comb begin
    pendVec = '0;
    pendVec[BIT_RXFULL]  = pendRxFull;
    pendVec[BIT_TXEMPTY] = pendTxEmpty;
    pendVec[BIT_BREAK]   = pendBrk;
    pendVec[BIT_TOUT]    = pendTout;
  end

  assign masked = pendVec & ienQ;
  assign irq    = |masked;

  assign rtsReady    = !(rxFlowEn && (rxLevel >= {1'b0, flowThld}));
  assign coreTxAvail = (txLevel != '0) && !(txFlowEn && !ctsIn);

  always_comb begin
    unique case (regAddr_e'(busAddr))
      ADDR_TXDATA: busRdData = '0;
      ADDR_RXDATA: busRdData = {24'd0, rxHead};
      ADDR_LEVELS: busRdData = {16'd0, txLevel, rxLevel};
      ADDR_IEN:    busRdData = ienQ;
      ADDR_ICLR:   busRdData = '0;
      ADDR_CTRL:   busRdData = {16'd0, ctrlQ};
      ADDR_THRESH: busRdData = {17'd0, txThld, 1'b0, rxThld};
      ADDR_MSTAT:  busRdData = masked;
      default:     busRdData = '0;
    endcase
  end

endmodule

// File: rtl/uart_fifo_irq.sv
module uart_fifo_irq
  import uart_irq_pkg::*;
#(
  parameter int DEPTH = 128
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        busWrEn,
  input  logic        busRdEn,
  input  logic [2:0]  busAddr,
  input  logic [31:0] busWrData,
  output logic [31:0] busRdData,
  input  logic        coreTxTake,
  output logic [7:0]  coreTxByte,
  output logic        coreTxAvail,
  input  logic        coreRxPut,
  input  logic [7:0]  coreRxByte,
  input  logic        coreBreak,
  input  logic        coreBitTick,
  input  logic        ctsIn,
  output logic        rtsReady,
  output logic        irq,
  output logic        loopbackEn,
  output logic        dmaReqEn
);

  dpStrobe_t          strobe;
  logic [7:0]         rxHead;
  logic [LEVEL_W-1:0] txLevel, rxLevel;
  logic               pendBrk, pendTout;

  uart_irq_datapath #(.DEPTH(DEPTH)) dp_i (
    .clk(clk), .rstN(rstN), .strobe(strobe),
    .coreTxTake(coreTxTake), .coreRxPut(coreRxPut), .coreRxByte(coreRxByte),
    .txHead(coreTxByte), .rxHead(rxHead), .txLevel(txLevel), .rxLevel(rxLevel)
  );

  uart_irq_control #(.DEPTH(DEPTH)) ctl_i (
    .clk(clk), .rstN(rstN),
    .busWrEn(busWrEn), .busRdEn(busRdEn), .busAddr(busAddr),
    .busWrData(busWrData), .busRdData(busRdData),
    .rxHead(rxHead), .txLevel(txLevel), .rxLevel(rxLevel),
    .coreRxPut(coreRxPut), .coreBreak(coreBreak), .coreBitTick(coreBitTick),
    .ctsIn(ctsIn), .strobe(strobe), .coreTxAvail(coreTxAvail),
    .rtsReady(rtsReady), .irq(irq), .loopbackEn(loopbackEn),
    .dmaReqEn(dmaReqEn), .pendBrk(pendBrk), .pendTout(pendTout)
  );

endmodule

// File: rtl/uart_irq_checker.sv
module uart_irq_checker #(
  parameter int DEPTH = 128
) (
  input logic        clk,
  input logic        rstN,
  input logic        busWrEn,
  input logic [2:0]  busAddr,
  input logic [31:0] busWrData,
  input logic        txPush,
  input logic        rxPop,
  input logic        coreTxTake,
  input logic        coreRxPut,
  input logic        coreBreak,
  input logic [7:0]  txLevel,
  input logic [7:0]  rxLevel,
  input logic        pendBrk,
  input logic        irq
);

  a_r1_level_bound: assert property (@(posedge clk) disable iff (!rstN)
    (txLevel <= 8'(DEPTH)) && (rxLevel <= 8'(DEPTH)));

  a_r1_full_drop: assert property (@(posedge clk) disable iff (!rstN)
    (txLevel == 8'(DEPTH)) && txPush && !coreTxTake |=> txLevel == 8'(DEPTH));

  a_r2_empty_read: assert property (@(posedge clk) disable iff (!rstN)
    (rxLevel == 8'd0) && rxPop && !coreRxPut |=> rxLevel == 8'd0);

  a_r2_rx_step: assert property (@(posedge clk) disable iff (!rstN)
    (rxLevel == $past(rxLevel)) || (rxLevel == $past(rxLevel) + 8'd1) ||
    (rxLevel == $past(rxLevel) - 8'd1));

  a_r5_break_set: assert property (@(posedge clk) disable iff (!rstN)
    coreBreak |=> pendBrk);

  a_r8_break_clear: assert property (@(posedge clk) disable iff (!rstN)
    busWrEn && (busAddr == 3'd4) && busWrData[7] && !coreBreak |=> !pendBrk);

  a_r7_irq_quiet: assert property (@(posedge clk) disable iff (!rstN)
    busWrEn && (busAddr == 3'd3) && ((busWrData & 32'h2083) == 32'd0) |=> !irq);

endmodule

bind uart_fifo_irq uart_irq_checker #(.DEPTH(DEPTH)) chk_i (
  .clk(clk), .rstN(rstN), .busWrEn(busWrEn), .busAddr(busAddr),
  .busWrData(busWrData), .txPush(strobe.txPush), .rxPop(strobe.rxPop),
  .coreTxTake(coreTxTake), .coreRxPut(coreRxPut), .coreBreak(coreBreak),
  .txLevel(txLevel), .rxLevel(rxLevel), .pendBrk(pendBrk), .irq(irq)
);

// File: tb/uart_fifo_irq_tb.sv
module uart_fifo_irq_tb_top;

  localparam int DEPTH = 16;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        busWrEn = 1'b0, busRdEn = 1'b0;
  logic [2:0]  busAddr = '0;
  logic [31:0] busWrData = '0;
  logic [31:0] busRdData;
  logic        coreTxTake = 1'b0;
  logic [7:0]  coreTxByte;
  logic        coreTxAvail;
  logic        coreRxPut = 1'b0;
  logic [7:0]  coreRxByte = '0;
  logic        coreBreak = 1'b0, coreBitTick = 1'b0, ctsIn = 1'b1;
  logic        rtsReady, irq, loopbackEn, dmaReqEn;

  int checks = 0;
  int fails = 0;

  always #2 clk = ~clk;

  uart_fifo_irq #(.DEPTH(DEPTH)) dut_i (.*);

  // {write, addr, data, expected read}
  localparam int NV = 12;
  localparam logic [67:0] VEC [NV] = '{
    {1'b1, 3'd3, 32'hFFFF_FFFF, 32'h0},
    {1'b0, 3'd3, 32'h0,         32'h0000_2083},
    {1'b1, 3'd6, 32'hFFFF_FFFF, 32'h0},
    {1'b0, 3'd6, 32'h0,         32'h0000_7F7F},
    {1'b1, 3'd5, 32'h1234_FFFF, 32'h0},
    {1'b0, 3'd5, 32'h0,         32'h0000_FFFF},
    {1'b1, 3'd5, 32'h0,         32'h0},
    {1'b0, 3'd5, 32'h0,         32'h0},
    {1'b1, 3'd3, 32'h0,         32'h0},
    {1'b0, 3'd7, 32'h0,         32'h0},
    {1'b1, 3'd6, 32'h0000_0808, 32'h0},
    {1'b0, 3'd6, 32'h0,         32'h0000_0808}
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wrReg(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    busWrEn = 1'b1; busAddr = a; busWrData = d;
    @(negedge clk);
    busWrEn = 1'b0;
  endtask

  task automatic rdReg(input logic [2:0] a, output logic [31:0] d);
    @(negedge clk);
    busRdEn = 1'b1; busAddr = a;
    #1 d = busRdData;
    @(negedge clk);
    busRdEn = 1'b0;
  endtask

  task automatic putRx(input logic [7:0] b);
    @(negedge clk);
    coreRxPut = 1'b1; coreRxByte = b;
    @(negedge clk);
    coreRxPut = 1'b0;
  endtask

  task automatic pulseBreak();
    @(negedge clk); coreBreak = 1'b1;
    @(negedge clk); coreBreak = 1'b0;
  endtask

  task automatic pulseTick();
    @(negedge clk); coreBitTick = 1'b1;
    @(negedge clk); coreBitTick = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks + 1, fails);
    $finish;
  end

  initial begin
    logic [31:0] d;
    wait_cyc(3);
    rstN = 1'b1;
    wait_cyc(2);

    // R12 reset state
    rdReg(3'd2, d); chk("R12 levels", d, 32'h0);
    rdReg(3'd7, d); chk("R12 mstat", d, 32'h0);
    rdReg(3'd5, d); chk("R12 ctrl", d, 32'h0);
    chk("R12 irq", {31'd0, irq}, 32'h0);
    chk("R12 rtsReady", {31'd0, rtsReady}, 32'h1);
    chk("R12 txAvail", {31'd0, coreTxAvail}, 32'h0);
    rdReg(3'd6, d); chk("R3 reset thresh", d, 32'h0000_0808);

    // R3 R7 R11 register table
    for (int i = 0; i < NV; i++) begin
      if (VEC[i][67]) wrReg(VEC[i][66:64], VEC[i][63:32]);
      else begin
        rdReg(VEC[i][66:64], d);
        chk($sformatf("R3/R7/R11 table %0d", i), d, VEC[i][31:0]);
      end
    end

    // R4 transmit-empty
    wrReg(3'd6, 32'h0000_0308);
    wrReg(3'd3, 32'h2);
    wait_cyc(2);
    rdReg(3'd7, d); chk("R4 txEmpty set", d, 32'h2);
    chk("R7 irq high", {31'd0, irq}, 32'h1);
    wrReg(3'd0, 32'hA1); wrReg(3'd0, 32'hA2); wrReg(3'd0, 32'hA3);
    wait_cyc(2);
    rdReg(3'd7, d); chk("R4 txEmpty clear", d, 32'h0);
    rdReg(3'd2, d); chk("R1 tx level 3", d, 32'h0000_0300);
    chk("R1 tx head", {24'd0, coreTxByte}, 32'hA1);

    // R10 clear-to-send gating
    wrReg(3'd5, 32'h100);
    ctsIn = 1'b0; wait_cyc(1);
    chk("R10 cts low", {31'd0, coreTxAvail}, 32'h0);
    ctsIn = 1'b1; wait_cyc(1);
    chk("R10 cts high", {31'd0, coreTxAvail}, 32'h1);
    wrReg(3'd5, 32'h0);

    // R1 overfill drops writes
    for (int i = 0; i < 14; i++) wrReg(3'd0, 32'(8'hB0 + i));
    rdReg(3'd2, d); chk("R1 tx full", d, 32'h0000_1000);
    @(negedge clk); coreTxTake = 1'b1;
    @(negedge clk); coreTxTake = 1'b0;
    chk("R1 tx next head", {24'd0, coreTxByte}, 32'hA2);
    rdReg(3'd2, d); chk("R1 tx after take", d, 32'h0000_0F00);

    // R2 empty read
    rdReg(3'd1, d); chk("R2 empty read", d, 32'h0);
    rdReg(3'd2, d); chk("R2 empty count", d, 32'h0000_0F00);

    // R4 receive-full
    wrReg(3'd6, 32'h0000_0305);
    wrReg(3'd3, 32'h1);
    for (int i = 0; i < 5; i++) putRx(8'(8'h51 + i));
    wait_cyc(2);
    rdReg(3'd7, d); chk("R4 rxFull set", d, 32'h1);
    rdReg(3'd1, d); chk("R2 rx first", d, 32'h51);
    wait_cyc(2);
    rdReg(3'd7, d); chk("R4 rxFull clear", d, 32'h0);
    rdReg(3'd2, d); chk("R1 levels", d, 32'h0000_0F04);

    // R9 flow control
    wrReg(3'd5, 32'h84);
    wait_cyc(1);
    chk("R9 rts low at 4", {31'd0, rtsReady}, 32'h0);
    rdReg(3'd1, d); chk("R2 rx second", d, 32'h52);
    wait_cyc(1);
    chk("R9 rts high at 3", {31'd0, rtsReady}, 32'h1);
    putRx(8'h56);
    wait_cyc(1);
    chk("R9 rts low again", {31'd0, rtsReady}, 32'h0);
    wrReg(3'd5, 32'h0);
    wait_cyc(1);
    chk("R9 disabled", {31'd0, rtsReady}, 32'h1);

    // R5 R8 break
    wrReg(3'd3, 32'h80);
    pulseBreak();
    wait_cyc(2);
    rdReg(3'd7, d); chk("R5 break set", d, 32'h80);
    wrReg(3'd4, 32'h80);
    wait_cyc(1);
    rdReg(3'd7, d); chk("R8 break cleared", d, 32'h0);

    // R6 timeout of 3 bit times
    wrReg(3'd5, 32'h600);
    wrReg(3'd3, 32'h2000);
    pulseTick(); pulseTick();
    wait_cyc(2);
    rdReg(3'd7, d); chk("R6 not yet", d, 32'h0);
    pulseTick();
    wait_cyc(2);
    rdReg(3'd7, d); chk("R6 timeout set", d, 32'h2000);
    wrReg(3'd4, 32'h2000);
    wait_cyc(1);
    rdReg(3'd7, d); chk("R8 timeout cleared", d, 32'h0);

    // R8 all-ones clear
    wrReg(3'd3, 32'h2080);
    putRx(8'h57);
    pulseTick(); pulseTick(); pulseTick();
    pulseBreak();
    wait_cyc(2);
    rdReg(3'd7, d); chk("R8 both pending", d, 32'h2080);
    wrReg(3'd4, 32'hFFFF_FFFF);
    wait_cyc(1);
    rdReg(3'd7, d); chk("R8 all cleared", d, 32'h0);

    // R2 ordering, then R6 with empty queue
    for (int i = 0; i < 5; i++) begin
      rdReg(3'd1, d); chk("R2 rx order", d, 32'(8'h53 + i));
    end
    for (int i = 0; i < 5; i++) pulseTick();
    wait_cyc(2);
    rdReg(3'd7, d); chk("R6 empty no timeout", d, 32'h0);

    // R11 outputs
    wrReg(3'd5, 32'hC000);
    wait_cyc(1);
    chk("R11 loopback", {31'd0, loopbackEn}, 32'h1);
    chk("R11 dma", {31'd0, dmaReqEn}, 32'h1);
    wrReg(3'd5, 32'h0);

    // R7 disabled pending appears when enabled
    wrReg(3'd3, 32'h0);
    pulseBreak();
    wait_cyc(2);
    rdReg(3'd7, d); chk("R7 masked off", d, 32'h0);
    chk("R7 irq low", {31'd0, irq}, 32'h0);
    wrReg(3'd3, 32'h80);
    wait_cyc(1);
    rdReg(3'd7, d); chk("R7 shows when enabled", d, 32'h80);
    wrReg(3'd4, 32'h80);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

endmodule